// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Loader

This block is a master sequencer that loads a bitstream into a downstream FPGA through its byte-wide slave configuration port. A start strobe, together with a byte count, launches one load. The loader first pulls the program line low and waits for the target to answer by pulling its init line low. It then releases program and waits for the target to release init and to clear busy. After that it streams the bytes it receives on a valid/ready input onto the configuration data bus, with one configuration clock cycle per byte.

While the data phase runs, the loader watches three lines. If init falls, the target has found a checksum error, and the loader stops at once. If done rises before the last byte, the loader stops asking for bytes and goes straight to the completion check. With busy checking enabled, the loader waits for busy to clear after each byte. Every wait has its own timeout. Each timeout is expressed in microseconds and converted to system-clock cycles from a clock-frequency parameter. The program pulse has a minimum width given in nanoseconds. At the end of a load, a 3-bit status shows the outcome and a one-cycle pulse marks completion.

The byte input follows valid/ready rules. A byte is taken at a rising system-clock edge where both `s_valid_i` and `s_ready_o` are high. `s_ready_o` is high only while the loader waits for the next byte, bytes remain to be sent, done is low and init is high. The source may hold `s_valid_i` low for as long as it likes. The configuration clock then stays high and nothing is transferred. `s_ready_o` can fall without any byte being taken, for example when done rises. The source must not treat `s_ready_o` as a promise to take a byte.

Top module: `pcfg_loader`

## Requirements
- R1: After reset, all four control pins are high, the data bus is 0, `s_ready_o` is low and `status_o` is 0 (idle). In idle, a high `start_i` pulls `prog_n_o` low one cycle later and sets `status_o` to 1 (running). `start_i` has no effect while a load is running.
- R2: `prog_n_o` stays low for at least PROG_CYC = ceil(CLK_MHZ*PROG_NS/1000) cycles. It is released only on an edge where `init_n_i` is low. If that has not happened within INIT_CYC = CLK_MHZ*INIT_TO_US cycles of pulling program low, the load ends with status 3.
- R3: After program is released, `cclk_o` stays high. The loader waits for `init_n_i` high and `busy_i` low at the same edge. If that does not happen within INIT_CYC cycles, the load ends with status 4.
- R4: `cs_n_o` and `wr_n_o` fall together before the first byte and stay low through the whole data phase. At the normal end, `cs_n_o` rises one cycle before `wr_n_o`.
- R5: For each accepted byte, `cdata_o` takes the byte and `cclk_o` falls in the same cycle. `cclk_o` is low for HALF_CYC cycles and then high for at least HALF_CYC cycles. Each byte gives exactly one rising edge, and bytes go out in the order they were accepted.
- R6: `s_ready_o` follows the valid/ready rules stated above. While `s_valid_i` is low, the loader waits with `cclk_o` high.
- R7: If `init_n_i` is low at an edge during the data phase, while the loader is not at the point of ending it, the load ends at that edge with status 5.
- R8: If `done_i` is high while the loader waits for a byte, the data phase ends even though bytes remain, and the completion check follows.
- R9: With busy checking enabled, the loader waits after each byte until `busy_i` is low. If `busy_i` stays high for BUSY_CYC = CLK_MHZ*BUSY_TO_US cycles, the load ends with status 6.
- R10: After `wr_n_o` rises, the load ends with status 2 at the first edge where `done_i` is high and `init_n_i` is high. If that has not happened within DONE_CYC = CLK_MHZ*DONE_TO_US cycles, the load ends with status 7.
- R11: At the end of every load, `finish_o` is high for exactly one cycle. In that cycle `status_o` already holds the final code (2 to 7) and all four control pins are high. The code is held until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a load (only acted on in idle) |
| byte_count_i | input | CNT_W | Number of bytes to send, sampled with start_i |
| s_valid_i | input | 1 | Byte stream valid |
| s_data_i | input | 8 | Byte stream data |
| s_ready_o | output | 1 | Byte stream ready |
| prog_n_o | output | 1 | Program line to the target, active low |
| cs_n_o | output | 1 | Chip select to the target, active low |
| wr_n_o | output | 1 | Write strobe to the target, active low |
| cclk_o | output | 1 | Configuration clock |
| cdata_o | output | 8 | Configuration data bus |
| init_n_i | input | 1 | Init line from the target, active low |
| done_i | input | 1 | Done line from the target, high when configured |
| busy_i | input | 1 | Busy line from the target, high when busy |
| status_o | output | 3 | 0 idle, 1 running, 2 success, 3 init-assert timeout, 4 init-release timeout, 5 checksum error, 6 busy timeout, 7 done timeout |
| finish_o | output | 1 | One-cycle pulse at the end of a load |

## Verification
The bench stimulates a target that answers init early, late or never, holds busy after each byte, or raises done early. Against these cases it checks the following:
- A loader that releases program as soon as init falls would give a pulse shorter than the minimum width.
- A loader that ignores busy during the post-release wait would clock data too early.
- A loader that misses the mid-stream fall of init would keep clocking bytes after a checksum error.
- A loader that ignores early done would keep asking for bytes that the stream model then sends, which shows up as extra bytes.

Timeouts are tested at their exact cycle, and so are a zero byte count, gaps in the byte stream and a second start pulse in the middle of a load. Any difference in cycle timing shows up in the per-cycle comparison of every output pin.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE          = 3'd0,
    ST_RUN           = 3'd1,
    ST_OK            = 3'd2,
    ST_ERR_INIT_LOW  = 3'd3,
    ST_ERR_INIT_HIGH = 3'd4,
    ST_ERR_CRC       = 3'd5,
    ST_ERR_BUSY      = 3'd6,
    ST_ERR_DONE      = 3'd7
  } pcfg_status_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PROG,
    S_WAIT,
    S_FETCH,
    S_LOW,
    S_HIGH,
    S_BUSY,
    S_END_CS,
    S_END_WR,
    S_CHECK
  } pcfg_state_e;

  function automatic int unsigned cyc_from_ns(int unsigned mhz, int unsigned ns);
    int unsigned c;
    c = (mhz * ns + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pcfg_timer.sv
module pcfg_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (clr) begin
      cnt_o <= '0;
    end else if (cnt_o != {W{1'b1}}) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/pcfg_bytecnt.sv
module pcfg_bytecnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero_o
);

  logic [W-1:0] rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
    end else if (load) begin
      rem <= load_val;
    end else if (dec && (rem != '0)) begin
      rem <= rem - 1'b1;
    end
  end

  assign zero_o = (rem == '0);

endmodule

// File: rtl/pcfg_loader.sv
module pcfg_loader
  import pcfg_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 200,
  parameter int unsigned PROG_NS    = 300,
  parameter int unsigned INIT_TO_US = 500000,
  parameter int unsigned BUSY_TO_US = 5000,
  parameter int unsigned DONE_TO_US = 200000,
  parameter int unsigned HALF_CYC   = 2,
  parameter int unsigned CNT_W      = 24,
  parameter bit          CHECK_BUSY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_count_i,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  output logic             s_ready_o,
  output logic             prog_n_o,
  output logic             cs_n_o,
  output logic             wr_n_o,
  output logic             cclk_o,
  output logic [7:0]       cdata_o,
  input  logic             init_n_i,
  input  logic             done_i,
  input  logic             busy_i,
  output logic [2:0]       status_o,
  output logic             finish_o
);

  localparam int unsigned PROG_CYC = cyc_from_ns(CLK_MHZ, PROG_NS);
  localparam int unsigned INIT_CYC = max2(CLK_MHZ * INIT_TO_US, PROG_CYC);
  localparam int unsigned BUSY_CYC = max2(CLK_MHZ * BUSY_TO_US, 1);
  localparam int unsigned DONE_CYC = max2(CLK_MHZ * DONE_TO_US, 1);
  localparam int unsigned HALF_EFF = max2(HALF_CYC, 1);
  localparam int unsigned TOP_CYC  = max2(max2(INIT_CYC, BUSY_CYC), max2(DONE_CYC, HALF_EFF));
  localparam int unsigned TW       = $clog2(TOP_CYC + 1);

  localparam logic [TW-1:0] LIM_PROG = TW'(PROG_CYC - 1);
  localparam logic [TW-1:0] LIM_INIT = TW'(INIT_CYC - 1);
  localparam logic [TW-1:0] LIM_BUSY = TW'(BUSY_CYC - 1);
  localparam logic [TW-1:0] LIM_DONE = TW'(DONE_CYC - 1);
  localparam logic [TW-1:0] LIM_HALF = TW'(HALF_EFF - 1);

  pcfg_state_e  state, n_state, after_high;
  pcfg_status_e status, n_status, code;
  logic         n_prog, n_cs, n_wr, n_cclk, n_fin, abort;
  logic [7:0]   n_data;
  logic         tmr_clr, cnt_load, cnt_dec, rem_zero;
  logic [TW-1:0] elapsed;

  pcfg_timer #(.W(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .cnt_o (elapsed)
  );

  pcfg_bytecnt #(.W(CNT_W)) u_bytecnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (byte_count_i),
    .dec      (cnt_dec),
    .zero_o   (rem_zero)
  );

  generate
    if (CHECK_BUSY) begin : g_busy_on
      assign after_high = S_BUSY;
    end else begin : g_busy_off
      assign after_high = S_FETCH;
    end
  endgenerate

  assign s_ready_o = (state == S_FETCH) && !rem_zero && !done_i && init_n_i;

  always_comb begin
    n_state  = state;
    n_status = status;
    n_prog   = prog_n_o;
    n_cs     = cs_n_o;
    n_wr     = wr_n_o;
    n_cclk   = cclk_o;
    n_data   = cdata_o;
    n_fin    = 1'b0;
    tmr_clr  = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    abort    = 1'b0;
    code     = status;
    unique case (state)
      S_IDLE: begin
        if (start_i) begin
          n_state  = S_PROG;
          n_prog   = 1'b0;
          n_status = ST_RUN;
          tmr_clr  = 1'b1;
          cnt_load = 1'b1;
        end
      end
      S_PROG: begin
        if ((elapsed >= LIM_PROG) && !init_n_i) begin
          n_prog  = 1'b1;
          n_state = S_WAIT;
          tmr_clr = 1'b1;
        end else if (elapsed >= LIM_INIT) begin
          abort = 1'b1;
          code  = ST_ERR_INIT_LOW;
        end
      end
      S_WAIT: begin
        if (init_n_i && !busy_i) begin
          n_cs    = 1'b0;
          n_wr    = 1'b0;
          n_state = S_FETCH;
        end else if (elapsed >= LIM_INIT) begin
          abort = 1'b1;
          code  = ST_ERR_INIT_HIGH;
        end
      end
      S_FETCH: begin
        if (rem_zero || done_i) begin
          n_state = S_END_CS;
        end else if (!init_n_i) begin
          abort = 1'b1;
          code  = ST_ERR_CRC;
        end else if (s_valid_i) begin
          n_data  = s_data_i;
          n_cclk  = 1'b0;
          tmr_clr = 1'b1;
          n_state = S_LOW;
        end
      end
      S_LOW: begin
        if (!init_n_i) begin
          abort = 1'b1;
          code  = ST_ERR_CRC;
        end else if (elapsed >= LIM_HALF) begin
          n_cclk  = 1'b1;
          cnt_dec = 1'b1;
          tmr_clr = 1'b1;
          n_state = S_HIGH;
        end
      end
      S_HIGH: begin
        if (!init_n_i) begin
          abort = 1'b1;
          code  = ST_ERR_CRC;
        end else if (elapsed >= LIM_HALF) begin
          tmr_clr = 1'b1;
          n_state = after_high;
        end
      end
      S_BUSY: begin
        if (!init_n_i) begin
          abort = 1'b1;
          code  = ST_ERR_CRC;
        end else if (!busy_i) begin
          n_state = S_FETCH;
        end else if (elapsed >= LIM_BUSY) begin
          abort = 1'b1;
          code  = ST_ERR_BUSY;
        end
      end
      S_END_CS: begin
        n_cs    = 1'b1;
        n_state = S_END_WR;
      end
      S_END_WR: begin
        n_wr    = 1'b1;
        tmr_clr = 1'b1;
        n_state = S_CHECK;
      end
      S_CHECK: begin
        if (done_i && init_n_i) begin
          n_state  = S_IDLE;
          n_status = ST_OK;
          n_fin    = 1'b1;
        end else if (elapsed >= LIM_DONE) begin
          abort = 1'b1;
          code  = ST_ERR_DONE;
        end
      end
      default: n_state = S_IDLE;
    endcase
    if (abort) begin
      n_state  = S_IDLE;
      n_status = code;
      n_fin    = 1'b1;
      n_prog   = 1'b1;
      n_cs     = 1'b1;
      n_wr     = 1'b1;
      n_cclk   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      status   <= ST_IDLE;
      prog_n_o <= 1'b1;
      cs_n_o   <= 1'b1;
      wr_n_o   <= 1'b1;
      cclk_o   <= 1'b1;
      cdata_o  <= 8'h00;
      finish_o <= 1'b0;
    end else begin
      state    <= n_state;
      status   <= n_status;
      prog_n_o <= n_prog;
      cs_n_o   <= n_cs;
      wr_n_o   <= n_wr;
      cclk_o   <= n_cclk;
      cdata_o  <= n_data;
      finish_o <= n_fin;
    end
  end

  assign status_o = status;

endmodule

// File: rtl/pcfg_loader_sva.sv
module pcfg_loader_sva
  import pcfg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       s_ready_o,
  input logic       prog_n_o,
  input logic       cs_n_o,
  input logic       wr_n_o,
  input logic       cclk_o,
  input logic [7:0] cdata_o,
  input logic       init_n_i,
  input logic       done_i,
  input logic [2:0] status_o,
  input logic       finish_o
);

  p_run_status_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> status_o == ST_RUN);

  p_prog_needs_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n_o) && !finish_o |-> $past(!init_n_i));

  p_cs_then_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) && !finish_o |=> $rose(wr_n_o));

  p_cclk_low_in_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cclk_o |-> !cs_n_o && !wr_n_o);

  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cclk_o && $past(!cclk_o) |-> $stable(cdata_o));

  p_ready_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> init_n_i && !done_i && !cs_n_o && cclk_o);

  p_crc_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cclk_o && !init_n_i |=> finish_o && status_o == ST_ERR_CRC);

  p_fin_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |=> !finish_o);

  p_fin_pins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |-> prog_n_o && cs_n_o && wr_n_o && cclk_o && status_o >= 3'd2);

endmodule

bind pcfg_loader pcfg_loader_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_ready_o (s_ready_o),
  .prog_n_o  (prog_n_o),
  .cs_n_o    (cs_n_o),
  .wr_n_o    (wr_n_o),
  .cclk_o    (cclk_o),
  .cdata_o   (cdata_o),
  .init_n_i  (init_n_i),
  .done_i    (done_i),
  .status_o  (status_o),
  .finish_o  (finish_o)
);

// File: tb/pcfg_loader_tb.sv
`timescale 1ns/1ps
module pcfg_loader_tb;

  localparam int M_PROG = (200 * 300 + 999) / 1000;
  localparam int M_INIT = 200 * 2;
  localparam int M_BUSY = 200 * 1;
  localparam int M_DONE = 200 * 1;
  localparam int M_HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [15:0] byte_count_i = '0;
  logic s_valid_i = 1'b0;
  logic [7:0] s_data_i = '0;
  logic s_ready_o, prog_n_o, cs_n_o, wr_n_o, cclk_o, finish_o;
  logic [7:0] cdata_o;
  logic [2:0] status_o;
  logic init_n_i = 1'b1;
  logic done_i = 1'b0;
  logic busy_i = 1'b0;

  always #2.5 clk = ~clk;

  pcfg_loader #(
    .CLK_MHZ(200), .PROG_NS(300), .INIT_TO_US(2), .BUSY_TO_US(1),
    .DONE_TO_US(1), .HALF_CYC(2), .CNT_W(16), .CHECK_BUSY(1'b1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
    .prog_n_o(prog_n_o), .cs_n_o(cs_n_o), .wr_n_o(wr_n_o), .cclk_o(cclk_o),
    .cdata_o(cdata_o), .init_n_i(init_n_i), .done_i(done_i), .busy_i(busy_i),
    .status_o(status_o), .finish_o(finish_o)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog R11 act=hung exp=finished");
      finish_run();
    end
  end

  // target model knobs
  int init_lat, rel_lat, busy_len, busy_hold, done_after, crc_after;
  int pl, ph, nbytes, bcnt;
  bit seen_low, released, crc_hit, prev_cclk;
  logic [7:0] rx_q[$];

  task automatic stub_reset(input int il, input int rl, input int bl, input int bh,
                            input int da, input int ca);
    init_lat = il; rel_lat = rl; busy_len = bl; busy_hold = bh;
    done_after = da; crc_after = ca;
    pl = 0; ph = 0; nbytes = 0; bcnt = 0;
    seen_low = 0; released = 0; crc_hit = 0; prev_cclk = 1;
    rx_q.delete();
    init_n_i = 1'b1; done_i = 1'b0; busy_i = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    if (!prog_n_o) begin
      pl++; seen_low = 1; released = 0;
      if (init_lat >= 0 && pl >= init_lat) init_n_i = 1'b0;
    end else if (seen_low) begin
      released = 1; ph++;
      if (rel_lat >= 0 && ph >= rel_lat && !crc_hit) init_n_i = 1'b1;
    end
    if (!cs_n_o && cclk_o && !prev_cclk) begin
      rx_q.push_back(cdata_o);
      nbytes++;
      if (busy_len > 0) bcnt = busy_len;
    end
    prev_cclk = cclk_o;
    busy_i = (bcnt > 0) || (released && ph < busy_hold && nbytes == 0);
    if (bcnt > 0) bcnt--;
    if (crc_after > 0 && nbytes >= crc_after && released) begin
      crc_hit = 1; init_n_i = 1'b0;
    end
    done_i = released && done_after >= 0 && nbytes >= done_after;
  end

  // byte source
  logic [7:0] src_q[$];
  bit gap_mode = 0;
  bit hs_seen = 0;
  int gapc = 0;

  always @(negedge clk) hs_seen = s_valid_i && s_ready_o;

  always @(posedge clk) begin
    #1;
    if (hs_seen && src_q.size() > 0) void'(src_q.pop_front());
    gapc++;
    s_valid_i = (src_q.size() > 0) && (!gap_mode || (gapc % 3 != 0));
    s_data_i = (src_q.size() > 0) ? src_q[0] : 8'h00;
  end

  // behavioural reference model
  logic exp_prog = 1, exp_cs = 1, exp_wr = 1, exp_cclk = 1, exp_fin = 0;
  logic [7:0] exp_data = 0;
  logic [2:0] exp_status = 0;
  logic m_fetch = 0;
  int m_rem = 0;
  bit cmp_on = 0;
  wire exp_ready = m_fetch && (m_rem != 0) && !done_i && init_n_i;

  task automatic m_end(input int c);
    exp_status = 3'(c); exp_fin = 1; exp_prog = 1; exp_cs = 1; exp_wr = 1;
    exp_cclk = 1; m_fetch = 0;
  endtask

  task automatic model_run(input int count);
    int e;
    bit stop;
    exp_prog = 0; exp_status = 1; m_rem = count;
    e = 0;
    forever begin
      @(posedge clk);
      if (e >= M_PROG - 1 && !init_n_i) begin exp_prog = 1; break; end
      if (e >= M_INIT - 1) begin m_end(3); return; end
      e++;
    end
    e = 0;
    forever begin
      @(posedge clk);
      if (init_n_i && !busy_i) begin exp_cs = 0; exp_wr = 0; break; end
      if (e >= M_INIT - 1) begin m_end(4); return; end
      e++;
    end
    stop = 0;
    while (!stop) begin
      m_fetch = 1;
      forever begin
        @(posedge clk);
        if (m_rem == 0 || done_i) begin m_fetch = 0; stop = 1; break; end
        if (!init_n_i) begin m_end(5); return; end
        if (s_valid_i) begin exp_data = s_data_i; exp_cclk = 0; m_fetch = 0; break; end
      end
      if (!stop) begin
        e = 0;
        forever begin
          @(posedge clk);
          if (!init_n_i) begin m_end(5); return; end
          if (e >= M_HALF - 1) begin exp_cclk = 1; m_rem--; break; end
          e++;
        end
        e = 0;
        forever begin
          @(posedge clk);
          if (!init_n_i) begin m_end(5); return; end
          if (e >= M_HALF - 1) break;
          e++;
        end
        e = 0;
        forever begin
          @(posedge clk);
          if (!init_n_i) begin m_end(5); return; end
          if (!busy_i) break;
          if (e >= M_BUSY - 1) begin m_end(6); return; end
          e++;
        end
      end
    end
    @(posedge clk); exp_cs = 1;
    @(posedge clk); exp_wr = 1;
    e = 0;
    forever begin
      @(posedge clk);
      if (done_i && init_n_i) begin m_end(2); return; end
      if (e >= M_DONE - 1) begin m_end(7); return; end
      e++;
    end
  endtask

  initial begin
    wait (rst_n);
    forever begin
      @(posedge clk);
      exp_fin = 0;
      if (start_i) model_run(int'(byte_count_i));
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 prog_n_o", prog_n_o, exp_prog);
      chk("R4 cs_n_o", cs_n_o, exp_cs);
      chk("R4 wr_n_o", wr_n_o, exp_wr);
      chk("R5 cclk_o", cclk_o, exp_cclk);
      chk("R5 cdata_o", cdata_o, exp_data);
      chk("R6 s_ready_o", s_ready_o, exp_ready);
      chk("R1 status_o", status_o, exp_status);
      chk("R11 finish_o", finish_o, exp_fin);
    end
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 13 + 5) & 255);
  endfunction

  task automatic run_test(input string tag, input int seed, input int count,
                          input bit gaps, input int il, input int rl, input int bl,
                          input int bh, input int da, input int ca,
                          input int restart_at, input int exp_code, input int exp_n);
    int k;
    @(negedge clk);
    stub_reset(il, rl, bl, bh, da, ca);
    src_q.delete();
    gap_mode = gaps;
    for (int i = 0; i < count; i++) src_q.push_back(pat(seed, i));
    start_i = 1'b1; byte_count_i = 16'(count);
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    while (!finish_o && k < 4000) begin
      @(negedge clk);
      k++;
      if (k == restart_at) begin start_i = 1'b1; byte_count_i = 16'd3; end
      else start_i = 1'b0;
    end
    start_i = 1'b0;
    chk({tag, " finish seen"}, finish_o, 1);
    chk({tag, " final status"}, status_o, exp_code);
    chk({tag, " bytes clocked"}, rx_q.size(), exp_n);
    for (int i = 0; i < exp_n && i < rx_q.size(); i++)
      chk({tag, " R5 byte order"}, rx_q[i], pat(seed, i));
    @(negedge clk);
    chk({tag, " R11 pulse one cycle"}, finish_o, 0);
    chk({tag, " R11 status held"}, status_o, exp_code);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    stub_reset(10, 20, 0, 0, -1, -1);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #0;
    chk("R1 reset prog_n", prog_n_o, 1);
    chk("R1 reset cs_n", cs_n_o, 1);
    chk("R1 reset wr_n", wr_n_o, 1);
    chk("R1 reset cclk", cclk_o, 1);
    chk("R1 reset data", cdata_o, 0);
    chk("R1 reset status", status_o, 0);
    chk("R1 reset ready", s_ready_o, 0);
    chk("R1 reset finish", finish_o, 0);
    cmp_on = 1;
    repeat (3) @(negedge clk);

    // R5 R10 plain stream
    run_test("T1 R10 plain", 1, 16, 0, 10, 20, 0, 0, 16, -1, 0, 2, 16);
    chk("T1 R2 pulse width", pl, M_PROG);
    // R6 R9 R1 gaps, short busy, second start ignored
    run_test("T2 R6 R9 R1 gaps", 2, 12, 1, 4, 8, 3, 0, 12, -1, 30, 2, 12);
    // R2 init never asserts
    run_test("T3 R2 init timeout", 3, 4, 0, -1, 5, 0, 0, 4, -1, 0, 3, 0);
    chk("T3 R2 pulse to timeout", pl, M_INIT);
    // R2 early init, pulse still minimum
    run_test("T4 R2 early init", 4, 2, 0, 1, 3, 0, 0, 2, -1, 0, 2, 2);
    chk("T4 R2 pulse width", pl, M_PROG);
    // R3 init never released
    run_test("T5 R3 release timeout", 5, 4, 0, 5, -1, 0, 0, 4, -1, 0, 4, 0);
    // R7 checksum error after 5 bytes
    run_test("T6 R7 crc", 6, 10, 0, 5, 5, 0, 0, -1, 5, 0, 5, 5);
    // R8 early done after 6 of 10
    run_test("T7 R8 early done", 7, 10, 0, 5, 5, 0, 0, 6, -1, 0, 2, 6);
    // R9 busy too long
    run_test("T8 R9 busy timeout", 8, 3, 0, 5, 5, 300, 0, 3, -1, 0, 6, 1);
    // R10 done never
    run_test("T9 R10 done timeout", 9, 4, 0, 5, 5, 0, 0, -1, -1, 0, 7, 4);
    // R10 zero byte count
    run_test("T10 R10 zero count", 10, 0, 0, 5, 5, 0, 0, 0, -1, 0, 2, 0);
    // R3 busy held after init release
    run_test("T11 R3 busy hold", 11, 8, 0, 5, 5, 0, 40, 8, -1, 0, 2, 8);
    // R7 checksum error on first byte with gaps
    run_test("T12 R7 crc first", 12, 6, 1, 5, 5, 2, 0, -1, 1, 0, 5, 1);

    finish_run();
  end

endmodule